// File: doc/BRIEF.md
# Disk Block Stream Checker

This block sits behind a bit decoder that turns a disk track into bytes. It takes the decoded bytes one block at a time. The first byte of each block gives the block's type, and the type sets how many bytes follow. After the data come two CRC bytes. The checker runs every byte of the block, CRC bytes included, through a 16-bit CRC register. A block is intact when the register reads zero after the last CRC byte. When the block ends, the checker gives a one-cycle done pulse together with a pass/fail flag.

Errors fall into two classes. A failed CRC marks only that one block as bad, and checking goes on with the next block. Two conditions end the stream. The first is a type byte outside the legal range; its value is kept for reporting. The second is a sized block that follows a block which failed its CRC, because the size field it needs can no longer be trusted. After either one, the checker stays silent until it is reset.

The control is one state machine with five states:
- `ST_IDLE` waits for a block start.
- `ST_BODY` counts the data bytes.
- `ST_CRC_LO` and `ST_CRC_HI` take the two CRC bytes.
- `ST_HALT` is where the checker stays after a terminating error.

Its transitions are:
- From `ST_IDLE`, a legal type byte goes to `ST_BODY`. It goes straight to `ST_CRC_LO` when the block holds only its type byte.
- From `ST_IDLE`, an illegal type, or a type 4 after a failed block, goes to `ST_HALT`.
- From `ST_BODY`, the last data byte goes to `ST_CRC_LO`.
- Each CRC byte advances the machine: `ST_CRC_LO` to `ST_CRC_HI`, then `ST_CRC_HI` back to `ST_IDLE`.
- Only reset leaves `ST_HALT`.

Top module: `blk_stream_chk`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared to zero, the stored size is cleared, and the checker returns to waiting for a block start. This holds even in the middle of a block.
- R2: In the idle state, a byte counts as a type byte only when `in_vld` and `in_start` are both high. Valid bytes without `in_start` are ignored while idle. An `in_start` that arrives inside a block is ignored, and its byte is taken as an ordinary block byte.
- R3: A block's length counts the type byte. Type 1 blocks are 56 bytes long, type 2 blocks are 2 bytes, and type 3 blocks are 16 bytes. Two CRC bytes follow every block. `blk_done` is high for exactly one cycle, in the cycle after the second CRC byte is accepted, and at no other time.
- R4: The CRC register is loaded with 0x8000 on the type byte. The register shifts right, and each data bit enters at bit 15, least significant bit of each byte first. Whenever a 1 shifts out of bit 0, the register is XORed with 0x8408 (the polynomial x^16+x^12+x^5+1). The low CRC byte comes first. `crc_err` is set at `blk_done` exactly when the register is not zero after both CRC bytes, and it keeps that value until the next `blk_done`.
- R5: A CRC failure does not stop the stream. The next block is checked normally, and `crc_err` follows that block's own result.
- R6: A type 4 block is N+1 bytes long, type byte included. N is the 16-bit value held at byte offsets 13 (low byte) and 14 (high byte) of the most recent type 3 block, where the type byte is offset 0. N = 0 gives a block made of the type byte alone.
- R7: A type byte outside 1..4 causes three things. `stream_term` pulses for one cycle in the next cycle. `type_err` becomes set, and `type_err_val` holds the offending value. Both stay unchanged until reset, and no `blk_done` or further `stream_term` follows.
- R8: A type 4 byte that follows a block which failed its CRC also pulses `stream_term` and halts the checker. In this case `type_err` stays low, and no `blk_done` follows until reset.
- R9: Cycles with `in_vld` low never advance the checker, whatever `in_byte` and `in_start` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | The byte on `in_byte` is valid this cycle |
| in_start | input | 1 | The valid byte is the first byte of a block |
| in_byte | input | 8 | Decoded byte |
| blk_done | output | 1 | One-cycle pulse when a block's CRC bytes have been taken |
| crc_err | output | 1 | CRC result of the most recent block (1 = failed) |
| type_err | output | 1 | An illegal type byte was seen (sticky) |
| type_err_val | output | 8 | The illegal type value |
| stream_term | output | 1 | One-cycle pulse when the stream is terminated |

## Verification
The bench targets these corner cases and the failure each one would expose:
- A block whose size field is zero. A design that counted the type byte wrongly would hang, waiting for a data byte that never comes.
- A start strobe inside a block. A design that resynchronized on it would restart the block and give no done pulse at the expected point.
- A type 4 block after a failed type 3 block. This must terminate, and a design that only flagged the CRC error would run on.
- A type 4 block separated from its type 3 block by another block. This checks that the size is taken from the last type 3 block and not from the block just before it.

Random lengths and stall gaps catch off-by-one errors in the counters and any stall that is wrongly counted as a byte. Single-bit corruption of either the data or the stored CRC exposes a CRC step that is reflected wrongly or seeded wrongly.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_SEED      = 16'h8000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_HALT
    } chk_state_e;

    // One byte through the shift-in CRC register, bit 0 of the byte first.
    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        logic        cy;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            cy = r[0];
            r  = {din[i], r[15:1]};
            if (cy) r = r ^ CRC_POLY_REFL;
        end
        return r;
    endfunction

endpackage

// File: rtl/dbc_crc_unit.sv
module dbc_crc_unit
    import dbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        advance,
    input  logic [7:0]  din,
    output logic [15:0] crc_next
);
    logic [15:0] crc_q;
    logic [15:0] base;

    assign base     = restart ? CRC_SEED : crc_q;
    assign crc_next = crc_step(base, din);

    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= CRC_SEED;
        else if (advance) crc_q <= crc_next;
    end
endmodule

// File: rtl/dbc_len_unit.sv
module dbc_len_unit #(
    parameter int CNT_W    = 17,
    parameter int LEN_T1   = 56,
    parameter int LEN_T2   = 2,
    parameter int LEN_T3   = 16,
    parameter int SIZE_OFS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       type_in,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] pos,
    input  logic [7:0]       din,
    output logic [CNT_W-1:0] blk_len
);
    localparam logic [CNT_W-1:0] OFS_LO = CNT_W'(SIZE_OFS);
    localparam logic [CNT_W-1:0] OFS_HI = CNT_W'(SIZE_OFS + 1);

    logic [15:0] size_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (cap_en) begin
            if (pos == OFS_LO)      size_q[7:0]  <= din;
            else if (pos == OFS_HI) size_q[15:8] <= din;
        end
    end

    always_comb begin
        case (type_in)
            8'd1:    blk_len = CNT_W'(LEN_T1);
            8'd2:    blk_len = CNT_W'(LEN_T2);
            8'd3:    blk_len = CNT_W'(LEN_T3);
            8'd4:    blk_len = CNT_W'(size_q) + CNT_W'(1);
            default: blk_len = '0;
        endcase
    end
endmodule

// File: rtl/blk_stream_chk.sv
module blk_stream_chk
    import dbc_pkg::*;
#(
    parameter int CNT_W    = 17,
    parameter int LEN_T1   = 56,
    parameter int LEN_T2   = 2,
    parameter int LEN_T3   = 16,
    parameter int SIZE_OFS = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic       in_start,
    input  logic [7:0] in_byte,
    output logic       blk_done,
    output logic       crc_err,
    output logic       type_err,
    output logic [7:0] type_err_val,
    output logic       stream_term
);
    localparam logic [7:0]       TYPE_MIN   = 8'd1;
    localparam logic [7:0]       TYPE_MAX   = 8'd4;
    localparam logic [7:0]       TYPE_HDR   = 8'd3;
    localparam logic [7:0]       TYPE_SIZED = 8'd4;
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    chk_state_e       st_q, st_d;
    logic [CNT_W-1:0] pos_q, last_q, blk_len;
    logic [7:0]       type_q;
    logic             prev_bad_q;
    logic [15:0]      crc_next;
    logic             take_type, type_ok, sized_blocked, stop_now;
    logic             in_block, crc_adv, cap_en;

    assign take_type     = (st_q == ST_IDLE) && in_vld && in_start;
    assign type_ok       = (in_byte >= TYPE_MIN) && (in_byte <= TYPE_MAX);
    assign sized_blocked = (in_byte == TYPE_SIZED) && prev_bad_q;
    assign stop_now      = take_type && (!type_ok || sized_blocked);
    assign in_block      = (st_q == ST_BODY) || (st_q == ST_CRC_LO) || (st_q == ST_CRC_HI);
    assign crc_adv       = take_type || (in_vld && in_block);
    assign cap_en        = in_vld && (st_q == ST_BODY) && (type_q == TYPE_HDR);

    dbc_crc_unit i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (take_type),
        .advance  (crc_adv),
        .din      (in_byte),
        .crc_next (crc_next)
    );

    dbc_len_unit #(
        .CNT_W    (CNT_W),
        .LEN_T1   (LEN_T1),
        .LEN_T2   (LEN_T2),
        .LEN_T3   (LEN_T3),
        .SIZE_OFS (SIZE_OFS)
    ) i_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .type_in (in_byte),
        .cap_en  (cap_en),
        .pos     (pos_q),
        .din     (in_byte),
        .blk_len (blk_len)
    );

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (take_type) begin
                    if (stop_now)            st_d = ST_HALT;
                    else if (blk_len == ONE) st_d = ST_CRC_LO;
                    else                     st_d = ST_BODY;
                end
            end
            ST_BODY:   if (in_vld && pos_q == last_q) st_d = ST_CRC_LO;
            ST_CRC_LO: if (in_vld) st_d = ST_CRC_HI;
            ST_CRC_HI: if (in_vld) st_d = ST_IDLE;
            ST_HALT:   st_d = ST_HALT;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register and byte position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pos_q  <= '0;
            last_q <= '0;
            type_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_type) begin
                type_q <= in_byte;
                pos_q  <= ONE;
                last_q <= blk_len - ONE;
            end else if (in_vld && st_q == ST_BODY) begin
                pos_q <= pos_q + ONE;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_done     <= 1'b0;
            crc_err      <= 1'b0;
            type_err     <= 1'b0;
            type_err_val <= '0;
            stream_term  <= 1'b0;
            prev_bad_q   <= 1'b0;
        end else begin
            blk_done    <= 1'b0;
            stream_term <= 1'b0;
            if (stop_now) begin
                stream_term <= 1'b1;
                if (!type_ok) begin
                    type_err     <= 1'b1;
                    type_err_val <= in_byte;
                end
            end
            if (st_q == ST_CRC_HI && in_vld) begin
                blk_done   <= 1'b1;
                crc_err    <= (crc_next != 16'h0000);
                prev_bad_q <= (crc_next != 16'h0000);
            end
        end
    end
endmodule

// File: rtl/blk_stream_chk_sva.sv
module blk_stream_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       in_vld,
    input logic       blk_done,
    input logic       crc_err,
    input logic       type_err,
    input logic [7:0] type_err_val,
    input logic       stream_term
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!blk_done && !crc_err && !type_err && !stream_term)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done); // R3
    AST_CRC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_err) |-> blk_done); // R4
    AST_BADTYPE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(type_err) |-> stream_term); // R7
    AST_BADTYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |=> (type_err && $stable(type_err_val))); // R7
    AST_BADTYPE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> !blk_done); // R7
    AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stream_term |=> (!stream_term && !blk_done)); // R8
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_vld) |-> (!blk_done && !stream_term)); // R9
endmodule

bind blk_stream_chk blk_stream_chk_sva i_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .blk_done     (blk_done),
    .crc_err      (crc_err),
    .type_err     (type_err),
    .type_err_val (type_err_val),
    .stream_term  (stream_term)
);

// File: tb/test_blk_stream_chk.sv
module test_blk_stream_chk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] in_byte = '0;
    logic       blk_done, crc_err, type_err, stream_term;
    logic [7:0] type_err_val;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0]  blk [0:1023];
    int          blk_n;
    logic [15:0] last_size = '0;
    int          early;

    always #4 clk = ~clk;

    blk_stream_chk i_blk_stream_chk (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_start(in_start), .in_byte(in_byte),
        .blk_done(blk_done), .crc_err(crc_err), .type_err(type_err),
        .type_err_val(type_err_val), .stream_term(stream_term)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(int t);
        case (t)
            1: return 56;
            2: return 2;
            3: return 16;
            4: return int'(last_size) + 1;
            default: return 0;
        endcase
    endfunction

    // Register after data plus sixteen zero bits: the value to store as CRC.
    function automatic logic [15:0] ref_crc(int n);
        logic [15:0] r = 16'h8000;
        for (int k = 0; k < n * 8 + 16; k++) begin
            logic inb = (k < n * 8) ? blk[k / 8][k % 8] : 1'b0;
            logic outb = r[0];
            r = (r >> 1) | (16'(inb) << 15);
            if (outb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b0; in_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        last_size = '0;
    endtask

    task automatic put(logic [7:0] b, bit s);
        int gap = $urandom_range(0, 2);
        repeat (gap) begin
            @(negedge clk);
            in_vld = 1'b0; in_start = 1'($urandom_range(0, 1)); in_byte = 8'($urandom);
        end
        @(negedge clk);
        in_vld = 1'b1; in_start = s; in_byte = b;
        @(negedge clk);
        in_vld = 1'b0; in_start = 1'b0;
    endtask

    task automatic build(int t, bit corrupt, logic [15:0] size_field);
        int L = len_of(t);
        logic [15:0] c;
        blk[0] = 8'(t);
        for (int i = 1; i < L; i++) blk[i] = 8'($urandom);
        if (t == 3) begin
            blk[13] = size_field[7:0];
            blk[14] = size_field[15:8];
            last_size = size_field;
        end
        c = ref_crc(L);
        blk[L] = c[7:0];
        blk[L + 1] = c[15:8];
        blk_n = L + 2;
        if (corrupt) begin
            int p = $urandom_range(0, L + 1);
            blk[p] = blk[p] ^ (8'h01 << $urandom_range(0, 7));
        end
    endtask

    task automatic send_block(string req, bit exp_err, bit mid_start);
        early = 0;
        for (int i = 0; i < blk_n; i++) begin
            put(blk[i], (i == 0) ? 1'b1 : (mid_start ? 1'($urandom_range(0, 1)) : 1'b0));
            if (i < blk_n - 1 && blk_done) early++;
        end
        chk(req, "early done count", early, 0);
        chk(req, "blk_done after last CRC byte", int'(blk_done), 1);
        chk(req, "crc_err", int'(crc_err), int'(exp_err));
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R1", "blk_done after reset", int'(blk_done), 0);
        chk("R1", "crc_err after reset", int'(crc_err), 0);
        chk("R1", "type_err after reset", int'(type_err), 0);
        chk("R1", "stream_term after reset", int'(stream_term), 0);

        // R2: valid bytes without start are ignored while idle
        for (int i = 0; i < 5; i++) put(8'(i + 1), 1'b0);
        chk("R2", "blk_done on startless bytes", int'(blk_done), 0);
        build(2, 1'b0, 16'h0);
        send_block("R2", 1'b0, 1'b0);

        // R3, R4, R6: random rounds of all block types
        for (int r = 0; r < 6; r++) begin
            build(1, 1'b0, 16'h0); send_block("R3", 1'b0, 1'b0);
            build(2, 1'b0, 16'h0); send_block("R3", 1'b0, 1'b0);
            build(3, 1'b0, 16'($urandom_range(0, 40))); send_block("R3", 1'b0, 1'b0);
            build(4, 1'b0, 16'h0); send_block("R6", 1'b0, 1'b0);
        end

        // R2: start strobes inside a block are data
        build(3, 1'b0, 16'd9); send_block("R2", 1'b0, 1'b1);
        build(4, 1'b0, 16'h0); send_block("R2", 1'b0, 1'b1);

        // R6: size comes from the last type 3 block, with a block between them
        build(3, 1'b0, 16'd7); send_block("R6", 1'b0, 1'b0);
        build(2, 1'b0, 16'h0); send_block("R6", 1'b0, 1'b0);
        build(4, 1'b0, 16'h0); send_block("R6", 1'b0, 1'b0);
        // R6: zero size leaves only the type byte
        build(3, 1'b0, 16'd0); send_block("R6", 1'b0, 1'b0);
        build(4, 1'b0, 16'h0); send_block("R6", 1'b0, 1'b0);

        // R4, R5: corruption is flagged, and the stream continues
        for (int r = 0; r < 4; r++) begin
            build(1 + r % 3, 1'b1, 16'd3); send_block("R4", 1'b1, 1'b0);
            build(2, 1'b0, 16'h0); send_block("R5", 1'b0, 1'b0);
        end

        // R9: long stall with junk on the bus
        build(2, 1'b0, 16'h0);
        put(blk[0], 1'b1);
        repeat (20) begin
            @(negedge clk);
            in_vld = 1'b0; in_start = 1'b1; in_byte = 8'($urandom);
        end
        put(blk[1], 1'b0); put(blk[2], 1'b0);
        chk("R9", "blk_done before final byte", int'(blk_done), 0);
        put(blk[3], 1'b0);
        chk("R9", "blk_done after stall", int'(blk_done), 1);
        chk("R9", "crc_err after stall", int'(crc_err), 0);

        // R1: reset in the middle of a block
        build(1, 1'b0, 16'h0);
        for (int i = 0; i < 10; i++) put(blk[i], i == 0);
        do_reset();
        chk("R1", "blk_done after mid reset", int'(blk_done), 0);
        build(2, 1'b0, 16'h0); send_block("R1", 1'b0, 1'b0);

        // R8: sized block after a failed block
        build(3, 1'b1, 16'd5); send_block("R8", 1'b1, 1'b0);
        put(8'd4, 1'b1);
        chk("R8", "stream_term", int'(stream_term), 1);
        chk("R8", "type_err", int'(type_err), 0);
        build(2, 1'b0, 16'h0);
        early = 0;
        for (int i = 0; i < blk_n; i++) begin
            put(blk[i], i == 0);
            if (blk_done || stream_term) early++;
        end
        chk("R8", "outputs after halt", early, 0);

        // R7: illegal type values
        for (int k = 0; k < 5; k++) begin
            logic [7:0] v;
            case (k)
                0: v = 8'd0;
                1: v = 8'd5;
                2: v = 8'hFF;
                default: v = 8'($urandom_range(6, 254));
            endcase
            do_reset();
            put(v, 1'b1);
            chk("R7", "stream_term", int'(stream_term), 1);
            chk("R7", "type_err", int'(type_err), 1);
            chk("R7", "type_err_val", int'(type_err_val), int'(v));
            build(2, 1'b0, 16'h0);
            early = 0;
            for (int i = 0; i < blk_n; i++) begin
                put(blk[i], i == 0);
                if (blk_done || stream_term || !type_err || type_err_val != v) early++;
            end
            chk("R7", "state after illegal type", early, 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule